// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

This block is the shifting core of a serial peripheral interface master. A start strobe hands it a byte. It pulls the active-low slave select low and waits out a lead interval. It then runs sixteen serial clock transitions, shifting the byte out on one line while collecting a byte from the other. After a trail interval it raises a one-cycle done strobe with the received byte. The serial clock rate is not generated here. An external divider supplies a `tick` enable, and each tick is one half period of the serial clock.

Clock polarity, clock phase and bit order are taken from the mode inputs when each transfer launches. A start that arrives while a transfer is under way is held in a single-entry queue. If that request is waiting when the trail interval ends, the next byte starts on the following tick. The select stays low, and both the idle and the lead intervals are skipped. If no request is waiting, the select is released for an idle interval before another transfer can begin.

Top module: `spi_byte_master`

## Requirements
- R1: `sclk` rests at the `cpol` level (0 gives low, 1 gives high) whenever no transfer is running, and it is back at that level when the trail interval begins.
- R2: One transfer produces exactly 2*DATA_W transitions of `sclk`, at most one per tick, so successive transitions are at least one tick period apart.
- R3: With `cpha`=0, the first data bit is on `mosi` before the first `sclk` transition. `miso` is sampled on odd transitions (1, 3, …) and `mosi` changes on even ones.
- R4: With `cpha`=1, `mosi` changes on odd transitions and `miso` is sampled on even transitions (2, 4, …, 16).
- R5: With `lsb_first`=0, both lines carry the most significant bit first. With `lsb_first`=1, both carry the least significant bit first.
- R6: For a transfer started from rest, `ss_n` is low for at least LEAD_TICKS tick periods before the first `sclk` transition.
- R7: At least TRAIL_TICKS tick periods pass between the last `sclk` transition and either the release of `ss_n` or the next transfer. This holds for back-to-back transfers too.
- R8: Between two transfers that are not back to back, `ss_n` stays high for at least IDLE_TICKS tick periods.
- R9: A `start` seen while a transfer is in progress is queued. If it is pending when the trail interval ends, the next transfer begins without raising `ss_n` and without a lead interval.
- R10: `done` is high for exactly one cycle after the trail interval. `rx_byte` holds the received byte in that cycle and keeps it until the next `done`.
- R11: Synchronous reset leaves `ss_n` high, `done` low, `rx_byte` zero and no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Half-period enable from the external divider |
| tx_byte | input | DATA_W | Byte to send, captured with `start` |
| start | input | 1 | Transfer request strobe |
| cpol | input | 1 | Resting level of `sclk` |
| cpha | input | 1 | Phase: 0 samples on odd transitions, 1 samples on even transitions |
| lsb_first | input | 1 | Bit order: 0 sends MSB first, 1 sends LSB first |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Slave select, active low |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the engine with DATA_W=8, LEAD_TICKS=3, TRAIL_TICKS=2 and IDLE_TICKS=4. Because these three intervals differ from one another and are all larger than one, a timing bug that swaps them or shortens one shows up as a wrong interval length rather than passing unnoticed.

The bench drives `tick` at a divide of one for most runs, which packs the sixteen transitions into sixteen cycles. It also runs a divide of three, which exposes any transition that skips the tick enable. Its behavioural slave replies with a different byte on every transfer. That lets it confirm all eight combinations of polarity, phase and bit order, a request queued during the idle interval, and a request queued mid-transfer that must run back to back.

// File: rtl/spi_pkg.sv
// Package: shared types for the SPI master byte engine.
// Assumes nothing beyond IEEE 1800-2017.
package spi_pkg;

    // Sequencer phases: rest, select lead, shifting, trail, deselected gap
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } seq_st_t;

endpackage

// File: rtl/spi_seq.sv
// Module: spi_seq
// Sequences one transfer: lead, 2*DATA_W clock edges, trail, then either an
// idle gap or a direct back-to-back launch. It advances only on tick.
// Assumes LEAD_TICKS, TRAIL_TICKS and IDLE_TICKS are all at least 1.
module spi_seq #(
    parameter int DATA_W      = 8,
    parameter int LEAD_TICKS  = 2,
    parameter int TRAIL_TICKS = 1,
    parameter int IDLE_TICKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pend,
    output logic load,
    output logic edge_stb,
    output logic edge_odd,
    output logic edge_first,
    output logic trail_end,
    output logic ss_n,
    output logic ph,
    output logic at_rest
);
    import spi_pkg::*;

    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);
    localparam int TMAX  = (LEAD_TICKS > TRAIL_TICKS)
                         ? ((LEAD_TICKS > IDLE_TICKS) ? LEAD_TICKS : IDLE_TICKS)
                         : ((TRAIL_TICKS > IDLE_TICKS) ? TRAIL_TICKS : IDLE_TICKS);
    localparam int TW    = $clog2(TMAX + 1);

    seq_st_t        st;
    logic [TW-1:0]  tcnt;
    logic [EW-1:0]  ecnt;

    // Decode strobes for the datapath and the top level
    always_comb begin
        edge_stb   = (st == ST_XFER) && tick;
        edge_odd   = ~ecnt[0];
        edge_first = (ecnt == '0);
        trail_end  = (st == ST_TRAIL) && tick && (tcnt == TW'(TRAIL_TICKS - 1));
        load       = pend && ((st == ST_IDLE) || trail_end);
        ss_n       = (st == ST_IDLE) || (st == ST_GAP);
        at_rest    = (st == ST_IDLE);
    end

    // Phase sequencer with interval and edge counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            tcnt <= '0;
            ecnt <= '0;
            ph   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (pend) begin
                        st   <= ST_LEAD;
                        tcnt <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (tcnt == TW'(LEAD_TICKS - 1)) begin
                            st   <= ST_XFER;
                            ecnt <= '0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        ph <= ~ph;
                        if (ecnt == EW'(EDGES - 1)) begin
                            st   <= ST_TRAIL;
                            tcnt <= '0;
                        end else begin
                            ecnt <= ecnt + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (trail_end) begin
                        tcnt <= '0;
                        ecnt <= '0;
                        st   <= pend ? ST_XFER : ST_GAP;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (tcnt == TW'(IDLE_TICKS - 1)) begin
                            st <= ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_CLK_HOME_IN_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRAIL) |-> !ph); // R1
    AST_NO_EDGE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph) |-> !ss_n); // R2
    AST_B2B_KEEP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_end && pend) |=> (!ss_n && st == ST_XFER)); // R9

endmodule

// File: rtl/spi_shift.sv
// Module: spi_shift
// Transmit and receive shift registers. It decides on each clock edge
// whether to shift out or to sample, from the phase and the edge parity.
// Assumes the mode inputs are held stable for the whole transfer.
module spi_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              lsb_first,
    input  logic              cpha,
    input  logic              edge_stb,
    input  logic              edge_odd,
    input  logic              edge_first,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;
    logic              shift_en;
    logic              samp_en;

    // Phase 1 changes on odd edges but keeps bit 0 through edge 1
    always_comb begin
        shift_en = edge_stb && (cpha ? (edge_odd && !edge_first) : !edge_odd);
        samp_en  = edge_stb && (cpha ? !edge_odd : edge_odd);
        mosi     = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
    end

    // Transmit register: load at launch, then move toward the output end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_byte;
        end else if (shift_en) begin
            tx_sh <= lsb_first ? {1'b0, tx_sh[DATA_W-1:1]}
                               : {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // Receive register: enter each sample at the end that matches bit order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (samp_en) begin
            rx_word <= lsb_first ? {miso, rx_word[DATA_W-1:1]}
                                 : {rx_word[DATA_W-2:0], miso};
        end
    end

endmodule

// File: rtl/spi_byte_master.sv
// Module: spi_byte_master (top)
// SPI master for one byte per transfer. It holds a single-entry request queue,
// captures the mode at each launch, and registers the result and done strobe.
// Assumes tick comes from an external divider, one pulse per half period.
module spi_byte_master #(
    parameter int DATA_W      = 8,
    parameter int LEAD_TICKS  = 2,
    parameter int TRAIL_TICKS = 1,
    parameter int IDLE_TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done
);
    logic              pend;
    logic [DATA_W-1:0] hold;
    logic              cpol_l, cpha_l, lsb_l;
    logic              load, edge_stb, edge_odd, edge_first, trail_end, ph, at_rest;
    logic [DATA_W-1:0] rx_word;

    // Single-entry request queue; a new start wins over a launch clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            hold <= '0;
        end else if (start) begin
            pend <= 1'b1;
            hold <= tx_byte;
        end else if (load) begin
            pend <= 1'b0;
        end
    end

    // Capture the mode settings at each launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_l <= 1'b0;
            cpha_l <= 1'b0;
            lsb_l  <= 1'b0;
        end else if (load) begin
            cpol_l <= cpol;
            cpha_l <= cpha;
            lsb_l  <= lsb_first;
        end
    end

    // Result register and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= trail_end;
            if (trail_end) begin
                rx_byte <= rx_word;
            end
        end
    end

    // Serial clock: live polarity at rest, captured polarity while busy
    assign sclk = (at_rest ? cpol : cpol_l) ^ ph;

    spi_seq #(
        .DATA_W      (DATA_W),
        .LEAD_TICKS  (LEAD_TICKS),
        .TRAIL_TICKS (TRAIL_TICKS),
        .IDLE_TICKS  (IDLE_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pend       (pend),
        .load       (load),
        .edge_stb   (edge_stb),
        .edge_odd   (edge_odd),
        .edge_first (edge_first),
        .trail_end  (trail_end),
        .ss_n       (ss_n),
        .ph         (ph),
        .at_rest    (at_rest)
    );

    spi_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_byte  (hold),
        .lsb_first  (lsb_l),
        .cpha       (cpha_l),
        .edge_stb   (edge_stb),
        .edge_odd   (edge_odd),
        .edge_first (edge_first),
        .miso       (miso),
        .mosi       (mosi),
        .rx_word    (rx_word)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> done); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_byte)); // R10

endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    localparam int LEAD  = 3;
    localparam int TRAIL = 2;
    localparam int IDLE  = 4;

    // {cpol, cpha, lsb_first, tx byte}
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 8'hA5}, {3'b001, 8'h81}, {3'b010, 8'h3C}, {3'b011, 8'h01},
        {3'b100, 8'hF0}, {3'b101, 8'h6B}, {3'b110, 8'h80}, {3'b111, 8'hD2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [7:0] tx_byte = '0;
    logic start = 1'b0;
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic miso = 1'b0;
    logic sclk, mosi, ss_n, done;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0, div = 1, tcn = 0;
    bit finished = 0;

    // Monitor and slave model state
    int cyc = 0, en = 0, k = 0, tot_edges = 0, rises = 0;
    int t_fall = 0, t_rise = 0, t_first = 0, t_last = 0, gap = 0, min_sp = 1000;
    bit have_rise = 0, prev_ss = 1, prev_sclk = 0, first_mosi = 0;
    logic [7:0] sreg = '0, cap = '0, last_cap = '0;

    spi_byte_master #(.DATA_W(8), .LEAD_TICKS(LEAD), .TRAIL_TICKS(TRAIL),
                      .IDLE_TICKS(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_byte(tx_byte), .start(start),
        .cpol(m_cpol), .cpha(m_cpha), .lsb_first(m_lsb), .miso(miso),
        .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .rx_byte(rx_byte), .done(done));

    always #2.5 clk = ~clk;

    function automatic logic [7:0] reply(input int n);
        return 8'h5A + 8'(n * 29);
    endfunction

    function automatic logic pick(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    // Tick divider, driven on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tcn = 0;
            tick = 1'b0;
        end else begin
            tick = (tcn == div - 1);
            tcn = (tcn >= div - 1) ? 0 : tcn + 1;
        end
    end

    // Behavioural slave and interval monitor, on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            prev_ss = 1; prev_sclk = sclk; en = 0;
        end else begin
            if (prev_ss && !ss_n) begin
                t_fall = cyc;
                if (have_rise) gap = cyc - t_rise;
                en = 0; sreg = reply(k);
                miso = pick(sreg, 0, m_lsb);
                first_mosi = mosi;
            end else if (!prev_ss && ss_n) begin
                t_rise = cyc; have_rise = 1; rises = rises + 1;
            end else if (!ss_n && sclk != prev_sclk) begin
                en = en + 1; tot_edges = tot_edges + 1;
                if (en == 1) t_first = cyc;
                else if (cyc - t_last < min_sp) min_sp = cyc - t_last;
                t_last = cyc;
                if (en[0] != m_cpha)
                    cap = m_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
                else if (en < 16)
                    miso = pick(sreg, m_cpha ? (en - 1) / 2 : en / 2, m_lsb);
                if (en == 16) begin
                    last_cap = cap; k = k + 1; en = 0; sreg = reply(k);
                    miso = pick(sreg, 0, m_lsb);
                end
            end
            prev_ss = ss_n; prev_sclk = sclk;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] b);
        @(posedge clk); #1;
        tx_byte = b; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        bit ok;
        logic [7:0] r, exp;
        int e0, r0;
        // Reset state with a high polarity selected
        m_cpol = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(ss_n == 1'b1, "R11 ss_n in reset", ss_n, 1);
        chk(done == 1'b0, "R11 done in reset", done, 0);
        chk(rx_byte == 8'h00, "R11 rx_byte in reset", rx_byte, 0);
        chk(sclk == 1'b1, "R1 rest level after reset", sclk, 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(ss_n == 1'b1, "R11 no pending launch after reset", ss_n, 1);

        // Vector table: all eight mode combinations
        for (int i = 0; i < 8; i++) begin
            {m_cpol, m_cpha, m_lsb} = VEC[i][10:8];
            e0 = tot_edges;
            pulse_start(VEC[i][7:0]);
            wait_done(ok);
            chk(ok, "R10 done seen", ok, 1);
            r = rx_byte;
            exp = reply(k - 1);
            chk(r == exp, m_cpha ? "R4 received byte" : "R3 received byte", r, exp);
            @(negedge clk); #0.5;
            chk(last_cap == VEC[i][7:0], "R5 byte seen by slave", last_cap, VEC[i][7:0]);
            chk(tot_edges - e0 == 16, "R2 edge count", tot_edges - e0, 16);
            chk(t_first - t_fall >= LEAD, "R6 lead interval", t_first - t_fall, LEAD);
            chk(t_rise - t_last >= TRAIL, "R7 trail interval", t_rise - t_last, TRAIL);
            if (i > 0) chk(gap >= IDLE, "R8 idle interval", gap, IDLE);
            if (!m_cpha)
                chk(first_mosi == pick(VEC[i][7:0], 0, m_lsb), "R3 R5 first bit before edge",
                    first_mosi, pick(VEC[i][7:0], 0, m_lsb));
            @(posedge clk); #1;
            chk(done == 1'b0, "R10 done one cycle", done, 0);
            chk(rx_byte == r, "R10 result held", rx_byte, r);
            chk(sclk == m_cpol, "R1 rest level after transfer", sclk, m_cpol);
        end

        // Back-to-back: second request queued during the first transfer
        repeat (10) @(posedge clk);
        {m_cpol, m_cpha, m_lsb} = 3'b010;
        r0 = rises;
        pulse_start(8'hC3);
        repeat (6) @(posedge clk);
        pulse_start(8'h3C);
        wait_done(ok);
        chk(ok, "R9 first done", ok, 1);
        chk(ss_n == 1'b0, "R9 select held at first done", ss_n, 0);
        chk(rx_byte == reply(k - 1), "R9 first byte", rx_byte, reply(k - 1));
        @(negedge clk); #0.5;
        chk(last_cap == 8'hC3, "R5 first b2b byte at slave", last_cap, 8'hC3);
        e0 = t_last;
        wait_done(ok);
        chk(ok, "R9 second done", ok, 1);
        chk(rx_byte == reply(k - 1), "R9 second byte", rx_byte, reply(k - 1));
        @(negedge clk); #0.5;
        chk(rises - r0 == 1, "R9 single select release", rises - r0, 1);
        chk(last_cap == 8'h3C, "R9 second byte at slave", last_cap, 8'h3C);
        chk(t_first - e0 >= TRAIL + 1, "R7 trail kept between b2b", t_first - e0, TRAIL + 1);
        chk(t_first - e0 <= TRAIL + 1, "R9 no lead between b2b", t_first - e0, TRAIL + 1);

        // Slow tick: divide by three
        repeat (10) @(posedge clk);
        div = 3;
        {m_cpol, m_cpha, m_lsb} = 3'b101;
        min_sp = 1000;
        pulse_start(8'h96);
        wait_done(ok);
        chk(ok, "R2 slow done", ok, 1);
        chk(rx_byte == reply(k - 1), "R5 slow received byte", rx_byte, reply(k - 1));
        @(negedge clk); #0.5;
        chk(last_cap == 8'h96, "R5 slow byte at slave", last_cap, 8'h96);
        chk(min_sp >= 3, "R2 edge spacing follows tick", min_sp, 3);
        chk(t_first - t_fall >= 3 * LEAD, "R6 slow lead", t_first - t_fall, 3 * LEAD);
        chk(t_rise - t_last >= 3 * TRAIL, "R7 slow trail", t_rise - t_last, 3 * TRAIL);

        finish_run();
    end
endmodule